// File: doc/BRIEF.md
# Zero-Branch and Subroutine-Call Flow Sequencer

This unit owns the program counter of a small 8-bit core that fetches 16-bit instruction words from a byte-addressed, 21-bit program space. Every cycle it issues a fetch address. The word for that address comes back one cycle later and occupies the execute slot. Two instruction kinds are handled here. The first is a one-word relative jump, taken only while the zero flag is set. The second is a two-word absolute subroutine call, which can also copy the working, status and bank-select registers into shadow copies. Every other word passes through as a no-operation. The ALU, memories and register file live elsewhere.

A taken jump or a completed call redirects the fetch. The word that was already in flight becomes a dead slot. The unit marks that slot so the rest of the core can discard it. A call stores its return address on an internal hardware return stack with a pointer. The stack top, the pointer, a sticky overflow flag and the three shadow registers are all visible on the ports.

Top module: `flow_seq`

## Requirements
- R1: After reset the fetch address is 0, the first execute slot is marked flushed, and the stack pointer, stack top, overflow flag and all shadows read 0. Fetch addresses are always even.
- R2: A word whose upper byte is 0xE0 is a zero-branch, and its lower byte is a signed offset n. When the zero flag is 1 in the cycle the branch occupies the execute slot, the next fetch address is the branch address + 2 + 2n.
- R3: A zero-branch seen with the zero flag at 0 is not taken. The fetch continues sequentially, and no slot is flushed.
- R4: After a taken branch, and after the second word of a call, the next execute slot is flushed for exactly one cycle. The word in that slot has no effect, even if it encodes a branch.
- R5: Branch targets wrap modulo 2^21 in both directions.
- R6: The first word of a call has bits [15:9] = 1110110, a shadow bit s in bit 8, and k[7:0] in bits [7:0]. The next word supplies k[19:8] in bits [11:0]. In the cycle after that second word, the fetch address is k shifted left by one.
- R7: A call pushes its own address + 4. The stack top then shows that value, and the pointer grows by one.
- R8: A call with s = 0 leaves all three shadow registers unchanged.
- R9: A call with s = 1 loads the shadows with the working, status and bank-select values present in the cycle its second word is decoded.
- R10: A call made while the stack holds STACK_DEPTH entries sets the overflow flag, which stays set until reset. The pointer and the top entry remain unchanged.
- R11: Any word in the execute slot that is neither a zero-branch nor a call's first word advances the fetch address by 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| instrWord | input | 16 | Word returned for the previous cycle's fetch address |
| zeroFlag | input | 1 | Current zero flag |
| wregIn | input | DATA_W | Live working register |
| statusIn | input | DATA_W | Live status register |
| bsrIn | input | DATA_W | Live bank-select register |
| fetchAddr | output | PC_W | Byte address to fetch this cycle |
| flushSlot | output | 1 | Execute slot holds a discarded word |
| stackTop | output | PC_W | Most recent return address (0 when empty) |
| stackPtr | output | $clog2(STACK_DEPTH+1) | Number of stored return addresses |
| stackOverflow | output | 1 | Sticky: a push found the stack full |
| wregShadow | output | DATA_W | Shadow of the working register |
| statusShadow | output | DATA_W | Shadow of the status register |
| bsrShadow | output | DATA_W | Shadow of the bank-select register |

## Verification
The bench builds the unit with PC_W = 21, DATA_W = 8 and STACK_DEPTH = 4. With a shallow stack, a chain of six calls fills the stack and then overflows it within a few dozen cycles. This exercises the full-stack hold and the sticky flag. The full 21-bit counter width keeps wrap-around through both ends of the address space reachable with short negative and positive offsets. The bench varies the live register inputs every cycle, so the shadow values reveal the exact cycle in which they were captured.

// File: rtl/flow_seq_pkg.sv
`timescale 1ns/1ps
package flow_seq_pkg;
  localparam int WORD_W = 16;
  localparam int OFF_W  = 8;
  localparam int KLO_W  = 8;
  localparam int KHI_W  = 12;
  localparam int K_W    = KLO_W + KHI_W;
  localparam logic [7:0] BZ_OPCODE   = 8'hE0;
  localparam logic [6:0] CALL_OPCODE = 7'b1110110;

  typedef enum logic [1:0] {
    SLOT_EMPTY = 2'd0,
    SLOT_EXEC  = 2'd1,
    SLOT_CALL2 = 2'd2
  } slotT;

  typedef struct packed {
    logic             takeBranch;
    logic             doCall;
    logic             saveShadow;
    logic [OFF_W-1:0] brOffset;
    logic [K_W-1:0]   callTarget;
  } flowStrobeT;
endpackage

// File: rtl/flow_seq_ctrl.sv
`timescale 1ns/1ps
module flow_seq_ctrl
  import flow_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [WORD_W-1:0] wordIn,
  input  logic              zeroFlag,
  output flowStrobeT        strobe,
  output logic              flushSlot
);
  slotT             slotQ, slotD;
  logic             shadowReqQ, shadowReqD;
  logic [KLO_W-1:0] kLowQ, kLowD;
  logic             isBz, isCall1;

  assign isBz    = (wordIn[15:8] == BZ_OPCODE);
  assign isCall1 = (wordIn[15:9] == CALL_OPCODE);
  assign flushSlot = (slotQ == SLOT_EMPTY);

  always_comb begin
    slotD      = slotQ;
    shadowReqD = shadowReqQ;
    kLowD      = kLowQ;
    strobe            = '0;
    strobe.brOffset   = wordIn[OFF_W-1:0];
    strobe.callTarget = {wordIn[KHI_W-1:0], kLowQ};
    unique case (slotQ)
      SLOT_EMPTY: slotD = SLOT_EXEC;
      SLOT_EXEC: begin
        if (isBz && zeroFlag) begin
          strobe.takeBranch = 1'b1;
          slotD = SLOT_EMPTY;
        end else if (isCall1) begin
          shadowReqD = wordIn[8];
          kLowD      = wordIn[KLO_W-1:0];
          slotD      = SLOT_CALL2;
        end
      end
      SLOT_CALL2: begin
        strobe.doCall     = 1'b1;
        strobe.saveShadow = shadowReqQ;
        slotD = SLOT_EMPTY;
      end
      default: slotD = SLOT_EMPTY;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      slotQ      <= SLOT_EMPTY;
      shadowReqQ <= 1'b0;
      kLowQ      <= '0;
    end else begin
      slotQ      <= slotD;
      shadowReqQ <= shadowReqD;
      kLowQ      <= kLowD;
    end
  end

  // R4: a redirect leaves the in-flight word dead for one cycle
  a_r4_flush_after_redirect: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.takeBranch || strobe.doCall) |=> flushSlot);
  // R4: never two dead slots in a row
  a_r4_single_flush: assert property (@(posedge clk) disable iff (!rstN)
    flushSlot |=> !flushSlot);
  // R6: a first call word is always followed by its second-word cycle
  a_r6_call_pair: assert property (@(posedge clk) disable iff (!rstN)
    (slotQ == SLOT_EXEC && isCall1) |=> (slotQ == SLOT_CALL2));
  // R3: a clear zero flag never produces a jump
  a_r3_no_jump_when_clear: assert property (@(posedge clk) disable iff (!rstN)
    !zeroFlag |-> !strobe.takeBranch);
endmodule

// File: rtl/flow_seq_dp.sv
`timescale 1ns/1ps
module flow_seq_dp
  import flow_seq_pkg::*;
#(
  parameter int PC_W        = 21,
  parameter int DATA_W      = 8,
  parameter int STACK_DEPTH = 31,
  parameter int SP_W        = $clog2(STACK_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  flowStrobeT        strobe,
  input  logic [DATA_W-1:0] wregIn,
  input  logic [DATA_W-1:0] statusIn,
  input  logic [DATA_W-1:0] bsrIn,
  output logic [PC_W-1:0]   fetchAddr,
  output logic [PC_W-1:0]   stackTop,
  output logic [SP_W-1:0]   stackPtr,
  output logic              stackOverflow,
  output logic [DATA_W-1:0] wregShadow,
  output logic [DATA_W-1:0] statusShadow,
  output logic [DATA_W-1:0] bsrShadow
);
  logic [PC_W-1:0] fetchQ, slotAddrQ;
  logic [PC_W-1:0] brTarget, callTarget, retAddr;
  logic [PC_W-1:0] stackMem [STACK_DEPTH];
  logic [SP_W-1:0] spQ, topIdx;
  logic            stackFull, ovfQ;

  assign brTarget = slotAddrQ + PC_W'(2)
                  + {{(PC_W-OFF_W-1){strobe.brOffset[OFF_W-1]}}, strobe.brOffset, 1'b0};
  assign callTarget = PC_W'({strobe.callTarget, 1'b0});
  // slot holds the second call word, so +2 points past the whole call
  assign retAddr    = slotAddrQ + PC_W'(2);
  assign stackFull  = (spQ == SP_W'(STACK_DEPTH));
  assign topIdx     = spQ - SP_W'(1);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      fetchQ    <= '0;
      slotAddrQ <= '0;
    end else begin
      slotAddrQ <= fetchQ;
      if (strobe.takeBranch)  fetchQ <= brTarget;
      else if (strobe.doCall) fetchQ <= callTarget;
      else                    fetchQ <= fetchQ + PC_W'(2);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      spQ  <= '0;
      ovfQ <= 1'b0;
    end else if (strobe.doCall) begin
      if (stackFull) ovfQ <= 1'b1;
      else           spQ  <= spQ + SP_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    for (int e = 0; e < STACK_DEPTH; e++) begin
      if (strobe.doCall && !stackFull && spQ == SP_W'(e)) stackMem[e] <= retAddr;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wregShadow   <= '0;
      statusShadow <= '0;
      bsrShadow    <= '0;
    end else if (strobe.saveShadow) begin
      wregShadow   <= wregIn;
      statusShadow <= statusIn;
      bsrShadow    <= bsrIn;
    end
  end

  assign fetchAddr     = fetchQ;
  assign stackPtr      = spQ;
  assign stackOverflow = ovfQ;
  assign stackTop      = (spQ == '0) ? '0 : stackMem[topIdx];

  // R1: byte address of a 16-bit word stays even
  a_r1_fetch_even: assert property (@(posedge clk) disable iff (!rstN)
    fetchQ[0] == 1'b0);
  // R7: a successful push shows its return address at the top
  a_r7_push_visible: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.doCall && !stackFull) |=> (stackTop == $past(retAddr)));
  // R10: pushing a full stack freezes pointer and top, raises the flag
  a_r10_full_holds: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.doCall && stackFull) |=> ($stable(spQ) && $stable(stackTop) && ovfQ));
  // R10: flag is sticky
  a_r10_overflow_sticky: assert property (@(posedge clk) disable iff (!rstN)
    ovfQ |=> ovfQ);
  // R8: shadows move only on a save request
  a_r8_shadow_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.saveShadow |=> ($stable(wregShadow) && $stable(statusShadow) && $stable(bsrShadow)));
endmodule

// File: rtl/flow_seq.sv
`timescale 1ns/1ps
module flow_seq
  import flow_seq_pkg::*;
#(
  parameter int PC_W        = 21,
  parameter int DATA_W      = 8,
  parameter int STACK_DEPTH = 31,
  localparam int SP_W       = $clog2(STACK_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [15:0]       instrWord,
  input  logic              zeroFlag,
  input  logic [DATA_W-1:0] wregIn,
  input  logic [DATA_W-1:0] statusIn,
  input  logic [DATA_W-1:0] bsrIn,
  output logic [PC_W-1:0]   fetchAddr,
  output logic              flushSlot,
  output logic [PC_W-1:0]   stackTop,
  output logic [SP_W-1:0]   stackPtr,
  output logic              stackOverflow,
  output logic [DATA_W-1:0] wregShadow,
  output logic [DATA_W-1:0] statusShadow,
  output logic [DATA_W-1:0] bsrShadow
);
  flowStrobeT strobe;

  flow_seq_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .wordIn(instrWord), .zeroFlag(zeroFlag),
    .strobe(strobe), .flushSlot(flushSlot)
  );

  flow_seq_dp #(
    .PC_W(PC_W), .DATA_W(DATA_W), .STACK_DEPTH(STACK_DEPTH), .SP_W(SP_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .wregIn(wregIn), .statusIn(statusIn), .bsrIn(bsrIn),
    .fetchAddr(fetchAddr), .stackTop(stackTop), .stackPtr(stackPtr),
    .stackOverflow(stackOverflow), .wregShadow(wregShadow),
    .statusShadow(statusShadow), .bsrShadow(bsrShadow)
  );
endmodule

// File: tb/flow_seq_bench.sv
`timescale 1ns/1ps
module flow_seq_bench;
  localparam int PC_W  = 21;
  localparam int DW    = 8;
  localparam int DEPTH = 4;
  localparam int SP_W  = $clog2(DEPTH + 1);

  typedef struct {
    logic [PC_W-1:0] fetch;
    logic            flush;
    logic [PC_W-1:0] top;
    logic [SP_W-1:0] sp;
    logic            ovf;
    logic [DW-1:0]   w, s, b;
    string           tag;
  } itemT;

  logic clk = 1'b0, rstN = 1'b0, zf = 1'b0;
  logic [15:0] memWord;
  logic [31:0] cyc;
  logic [DW-1:0] wregIn, statusIn, bsrIn;
  logic [PC_W-1:0] fetchAddr, stackTop;
  logic flushSlot, stackOverflow;
  logic [SP_W-1:0] stackPtr;
  logic [DW-1:0] wregShadow, statusShadow, bsrShadow;

  logic [15:0] prog [int];
  itemT expQ [$];
  int vectors = 0, fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  flow_seq #(.PC_W(PC_W), .DATA_W(DW), .STACK_DEPTH(DEPTH)) u_flow_seq (
    .clk(clk), .rstN(rstN), .instrWord(memWord), .zeroFlag(zf),
    .wregIn(wregIn), .statusIn(statusIn), .bsrIn(bsrIn),
    .fetchAddr(fetchAddr), .flushSlot(flushSlot), .stackTop(stackTop),
    .stackPtr(stackPtr), .stackOverflow(stackOverflow),
    .wregShadow(wregShadow), .statusShadow(statusShadow), .bsrShadow(bsrShadow)
  );

  function automatic logic [15:0] progWord(logic [PC_W-1:0] a);
    return prog.exists(int'(a)) ? prog[int'(a)] : 16'h0000;
  endfunction

  // one-cycle synchronous program memory
  always @(posedge clk) memWord <= progWord(fetchAddr);
  always @(posedge clk) cyc <= rstN ? cyc + 1 : 32'd0;
  assign wregIn   = cyc[7:0];
  assign statusIn = ~cyc[7:0];
  assign bsrIn    = cyc[7:0] ^ 8'h5A;

  // driver: predicts per-cycle outputs from the requirements, then runs
  task automatic runTest(string tag, int n);
    logic [PC_W-1:0] mFetch = '0, mExec = '0, nxt;
    logic [PC_W-1:0] stk [DEPTH];
    int mSlot = 0, sp = 0;
    logic mS = 0, ovf = 0;
    logic [7:0] mK = '0, w = '0, s = '0, b = '0;
    logic [15:0] word;
    itemT it;
    for (int c = 0; c < n; c++) begin
      it.fetch = mFetch; it.flush = (mSlot == 0);
      it.top = (sp == 0) ? '0 : stk[sp-1];
      it.sp = SP_W'(sp); it.ovf = ovf; it.w = w; it.s = s; it.b = b; it.tag = tag;
      expQ.push_back(it);
      word = progWord(mExec);
      nxt = mFetch + 2;
      if (mSlot == 0) mSlot = 1;
      else if (mSlot == 1) begin
        if (word[15:8] == 8'hE0 && zf) begin
          nxt = mExec + 2 + {{12{word[7]}}, word[7:0], 1'b0};
          mSlot = 0;
        end else if (word[15:9] == 7'b1110110) begin
          mS = word[8]; mK = word[7:0]; mSlot = 2;
        end
      end else begin
        if (sp == DEPTH) ovf = 1;
        else begin stk[sp] = mExec + 2; sp++; end
        nxt = {word[11:0], mK, 1'b0};
        if (mS) begin w = c[7:0]; s = ~c[7:0]; b = c[7:0] ^ 8'h5A; end
        mSlot = 0;
      end
      mExec = mFetch; mFetch = nxt;
    end
    @(posedge clk); #1 rstN = 1'b1;
    wait (expQ.size() == 0);
    @(posedge clk); #1 rstN = 1'b0;
    repeat (2) @(posedge clk);
  endtask

  // monitor: compares each cycle half a period after the edge
  always @(negedge clk) begin
    if (rstN && expQ.size() > 0) begin
      itemT e;
      e = expQ.pop_front();
      vectors++;
      if ({fetchAddr, flushSlot, stackTop, stackPtr, stackOverflow, wregShadow, statusShadow, bsrShadow}
          !== {e.fetch, e.flush, e.top, e.sp, e.ovf, e.w, e.s, e.b}) begin
        fails++;
        $display("FAIL %s: got fetch=%h flush=%b top=%h sp=%0d ovf=%b sh=%h/%h/%h, expected fetch=%h flush=%b top=%h sp=%0d ovf=%b sh=%h/%h/%h",
          e.tag, fetchAddr, flushSlot, stackTop, stackPtr, stackOverflow, wregShadow, statusShadow, bsrShadow,
          e.fetch, e.flush, e.top, e.sp, e.ovf, e.w, e.s, e.b);
      end
    end
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got hung run, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    // R1 reset state and R11 non-matching words as no-ops
    prog.delete(); zf = 1;
    prog[2] = 16'hE100; prog[4] = 16'hFFFF; prog[6] = 16'hEE00;
    runTest("R1/R11", 8);
    // R3 branch with clear flag
    prog.delete(); zf = 0;
    prog[4] = 16'hE005; prog[6] = 16'hE0FF;
    runTest("R3", 8);
    // R2 taken forward jumps, R4 flushed word encodes a branch
    prog.delete(); zf = 1;
    prog[4] = 16'hE005; prog[6] = 16'hE003; prog[16] = 16'hE07F;
    runTest("R2/R4", 10);
    // R5 wrap below zero and past the top
    prog.delete(); zf = 1;
    prog[0] = 16'hE0FE; prog[21'h1FFFFE] = 16'hE001; prog[2] = 16'hE080;
    runTest("R5", 12);
    // R6 call decode, R7 push, R8 no shadow copy
    prog.delete(); zf = 0;
    prog[8] = 16'hEC45; prog[10] = 16'hF123;
    runTest("R6/R7/R8", 10);
    // R9 shadow copy then R8 a later s=0 call keeps it
    prog.delete(); zf = 0;
    prog[4] = 16'hED10; prog[6] = 16'hF00A;
    prog[21'h1420] = 16'hEC18; prog[21'h1422] = 16'hF000;
    runTest("R9/R8", 16);
    // R10 chain of six calls into a four-entry stack
    prog.delete(); zf = 0;
    for (int i = 0; i < 6; i++) begin
      prog[i*32]     = 16'hEC00 | 16'((i + 1) * 16);
      prog[i*32 + 2] = 16'hF000;
    end
    prog[192] = 16'hED00; prog[194] = 16'hF000;
    runTest("R10", 28);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule